// File: doc/BRIEF.md
# Two-wire serial EEPROM slave front end

This block is the bus-side front end of a serial memory with 8,192 byte-wide words. It watches the clock and data lines of a two-wire bus from the system clock domain. Each line passes through a synchronizer and a spike filter. After that the block finds start and stop conditions and answers only when the first byte carries its device address. A write header is followed by a two-byte word address and then data bytes. A read header returns bytes from an internal address counter. A random read is built from a write header that loads the address and stops after it, then a repeated start and a read header.

Incoming data bytes are handed one at a time to an external write engine, tagged with their word address. The engine is told to commit the staged bytes when a stop arrives, or to drop them when a new start arrives first. Read bytes come from a synchronous memory port with one cycle of latency. The block drives the data line through an open-drain enable only: a high enable pulls the line low. Bus timing is recovered by oversampling, so no logic is clocked by SCL.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset, and whenever no start has been seen since the last stop or NACK, `sda_oe_o` stays 0 and bus bits get no acknowledge.
- R2: Data bytes are committed only by a stop: `wr_commit_o` pulses one cycle after a stop if at least one data byte was received since the last start. If a start arrives first, `wr_abort_o` pulses instead.
- R3: The first byte after a start is sent MSB first. Bits [7:4] must equal 4'b1010 and bits [3:1] must equal `strap_i[2:0]`. Otherwise the byte gets no acknowledge and the slave stays silent until the next start.
- R4: Bit 0 of the header selects the operation. 0 means write: two word-address bytes follow, then data bytes. 1 means read: bytes are sent from the current address counter.
- R5: Each accepted byte gets an acknowledge (SDA held low) for the whole ninth SCL high phase. The slave changes SDA only after a falling SCL edge, so SDA stays stable while SCL is high.
- R6: The word address arrives high byte first. Only the low 13 bits are kept: the top three bits of the high byte are ignored.
- R7: The address counter advances by one after every data byte written or read, and wraps from 8191 to 0. Each written byte appears as a one-cycle `wr_valid_o` carrying `wr_addr_o` and `wr_data_o`.
- R8: During a read the master acknowledges each byte to get the next one. After a NACK the slave releases SDA and ignores clocks until a start.
- R9: While `busy_i` is high at the end of a header byte, the slave does not acknowledge its own address.
- R10: A pulse on SCL or SDA shorter than `FILT_CYC` system clocks is ignored and does not disturb the transfer in progress.
- R11: Each byte read uses a one-cycle `rd_req_o` pulse with `rd_addr_o`. `rd_data_i` must be valid on the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Data line pull-down enable (1 pulls low) |
| strap_i | input | 3 | Device select strap levels, bit 2 first on the bus |
| busy_i | input | 1 | Write engine busy, suppresses address acknowledge |
| wr_valid_o | output | 1 | One-cycle pulse per received data byte |
| wr_addr_o | output | 13 | Word address of the received byte |
| wr_data_o | output | 8 | Received data byte |
| wr_commit_o | output | 1 | Stop pulse: commit staged bytes |
| wr_abort_o | output | 1 | Start-before-stop pulse: drop staged bytes |
| rd_req_o | output | 1 | Read request pulse to the memory port |
| rd_addr_o | output | 13 | Read word address |
| rd_data_i | input | 8 | Read data, valid one cycle after the request |

## Verification
The hardest cases to reach from the ports are filter rejections inside a live transfer. A short rise of SDA while SCL is high would read as a false stop and a false start. A short SCL pulse while SCL is low would add a phantom bit. The bench puts both glitches inside a running write, one just before a data byte and one within its first bit. It then checks that the byte lands at the right address and is committed at the stop. The address-wrap and abort paths are reached by full bus transfers that start writing at word 8191, and by a write that a repeated start cuts short.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_AHI,
    PH_ALO,
    PH_WDAT,
    PH_RDAT
  } phase_e;
endpackage

// File: rtl/eeprom_i2c_filter.sv
module eeprom_i2c_filter #(
  parameter int FILT_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   sampled;

  assign sampled = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      // accept a new level only after FILT_CYC consecutive disagreeing samples
      if (sampled != line_o) begin
        if (cnt_q == CW'(FILT_CYC - 1)) begin
          line_o <= sampled;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/eeprom_i2c_events.sv
module eeprom_i2c_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
endmodule

// File: rtl/eeprom_i2c_core.sv
module eeprom_i2c_core
  import eeprom_i2c_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  output logic              sda_oe_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o,
  output logic              wr_abort_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output phase_e            phase_o
);
  localparam int HI_W = ADDR_W - 8;

  phase_e            phase_q;
  logic [3:0]        cnt_q;
  logic              ack_slot_q;
  logic              ack_go_q;
  logic              rw_q;
  logic              m_ack_q;
  logic              wr_any_q;
  logic              rd_pend_q;
  logic [6:0]        sr_q;
  logic [7:0]        tx_q;
  logic [7:0]        rd_buf_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        rx_byte;
  logic              hdr_match;

  assign rx_byte   = {sr_q, sda_i};
  assign hdr_match = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3:1] == strap_i);
  assign phase_o   = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      ack_slot_q  <= 1'b0;
      ack_go_q    <= 1'b0;
      rw_q        <= 1'b0;
      m_ack_q     <= 1'b0;
      wr_any_q    <= 1'b0;
      rd_pend_q   <= 1'b0;
      sr_q        <= '0;
      tx_q        <= '0;
      rd_buf_q    <= '0;
      addr_q      <= '0;
      sda_oe_o    <= 1'b0;
      wr_valid_o  <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_commit_o <= 1'b0;
      wr_abort_o  <= 1'b0;
      rd_req_o    <= 1'b0;
      rd_addr_o   <= '0;
    end else begin
      wr_valid_o  <= 1'b0;
      wr_commit_o <= 1'b0;
      wr_abort_o  <= 1'b0;
      rd_req_o    <= 1'b0;
      rd_pend_q   <= rd_req_o;
      if (rd_pend_q) rd_buf_q <= rd_data_i;

      if (start_i) begin
        phase_q    <= PH_HDR;
        cnt_q      <= '0;
        ack_slot_q <= 1'b0;
        sda_oe_o   <= 1'b0;
        if (wr_any_q) begin
          wr_abort_o <= 1'b1;
          wr_any_q   <= 1'b0;
        end
      end else if (stop_i) begin
        phase_q    <= PH_IDLE;
        cnt_q      <= '0;
        ack_slot_q <= 1'b0;
        sda_oe_o   <= 1'b0;
        if (wr_any_q) begin
          wr_commit_o <= 1'b1;
          wr_any_q    <= 1'b0;
        end
      end else if (phase_q != PH_IDLE) begin
        if (rise_i) begin
          if (ack_slot_q) begin
            if (phase_q == PH_RDAT) begin
              m_ack_q <= ~sda_i;
              addr_q  <= addr_q + ADDR_W'(1);
              if (!sda_i) begin
                rd_req_o  <= 1'b1;
                rd_addr_o <= addr_q + ADDR_W'(1);
              end
            end
          end else if (cnt_q < 4'd8) begin
            cnt_q <= cnt_q + 4'd1;
            sr_q  <= rx_byte[6:0];
            if (cnt_q == 4'd7) begin
              unique case (phase_q)
                PH_HDR: begin
                  ack_go_q <= hdr_match & ~busy_i;
                  rw_q     <= sda_i;
                  if (hdr_match && !busy_i && sda_i) begin
                    rd_req_o  <= 1'b1;
                    rd_addr_o <= addr_q;
                  end
                end
                PH_AHI: begin
                  ack_go_q             <= 1'b1;
                  addr_q[ADDR_W-1:8]   <= rx_byte[HI_W-1:0];
                end
                PH_ALO: begin
                  ack_go_q    <= 1'b1;
                  addr_q[7:0] <= rx_byte;
                end
                PH_WDAT: begin
                  ack_go_q   <= 1'b1;
                  wr_valid_o <= 1'b1;
                  wr_addr_o  <= addr_q;
                  wr_data_o  <= rx_byte;
                  wr_any_q   <= 1'b1;
                  addr_q     <= addr_q + ADDR_W'(1);
                end
                default: ack_go_q <= 1'b0;
              endcase
            end
          end
        end

        if (fall_i) begin
          if (ack_slot_q) begin
            ack_slot_q <= 1'b0;
            cnt_q      <= '0;
            sda_oe_o   <= 1'b0;
            unique case (phase_q)
              PH_HDR: begin
                if (!ack_go_q) begin
                  phase_q <= PH_IDLE;
                end else if (rw_q) begin
                  phase_q  <= PH_RDAT;
                  sda_oe_o <= ~rd_buf_q[7];
                  tx_q     <= {rd_buf_q[6:0], 1'b0};
                end else begin
                  phase_q <= PH_AHI;
                end
              end
              PH_AHI:  phase_q <= PH_ALO;
              PH_ALO:  phase_q <= PH_WDAT;
              PH_WDAT: phase_q <= PH_WDAT;
              PH_RDAT: begin
                if (m_ack_q) begin
                  sda_oe_o <= ~rd_buf_q[7];
                  tx_q     <= {rd_buf_q[6:0], 1'b0};
                end else begin
                  phase_q <= PH_IDLE;
                end
              end
              default: phase_q <= PH_IDLE;
            endcase
          end else if (cnt_q == 4'd8) begin
            ack_slot_q <= 1'b1;
            sda_oe_o   <= (phase_q != PH_RDAT) && ack_go_q;
          end else if (phase_q == PH_RDAT && cnt_q != 4'd0) begin
            sda_oe_o <= ~tx_q[7];
            tx_q     <= {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eeprom_i2c_pkg::*;
#(
  parameter int FILT_CYC    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o,
  output logic              wr_abort_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] filt_lines;
  logic               start_ev, stop_ev, rise_ev, fall_ev;
  phase_e             phase;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    eeprom_i2c_filter #(
      .FILT_CYC   (FILT_CYC),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end

  eeprom_i2c_events u_events (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (filt_lines[1]),
    .sda_i  (filt_lines[0]),
    .start_o(start_ev),
    .stop_o (stop_ev),
    .rise_o (rise_ev),
    .fall_o (fall_ev)
  );

  eeprom_i2c_core #(.ADDR_W(ADDR_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_ev),
    .stop_i     (stop_ev),
    .rise_i     (rise_ev),
    .fall_i     (fall_ev),
    .sda_i      (filt_lines[0]),
    .strap_i    (strap_i),
    .busy_i     (busy_i),
    .sda_oe_o   (sda_oe_o),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .wr_commit_o(wr_commit_o),
    .wr_abort_o (wr_abort_o),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_data_i  (rd_data_i),
    .phase_o    (phase)
  );
endmodule

// File: rtl/eeprom_i2c_slave_chk.sv
module eeprom_i2c_slave_chk
  import eeprom_i2c_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sda_oe_o,
  input logic              wr_valid_o,
  input logic              wr_commit_o,
  input logic              wr_abort_o,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              fall_ev,
  input phase_e            phase
);
  logic [ADDR_W-1:0] last_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_rd_q <= '0;
    else if (rd_req_o) last_rd_q <= rd_addr_o;
  end

  assert_silent_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_IDLE) |-> !sda_oe_o);

  assert_commit_after_stop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |-> $past(stop_ev));

  assert_abort_after_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_abort_o |-> $past(start_ev));

  assert_sda_moves_after_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> $past(fall_ev || start_ev || stop_ev));

  assert_seq_read_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && phase == PH_RDAT) |-> (rd_addr_o == last_rd_q + ADDR_W'(1)));

  assert_no_wr_rd_overlap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_valid_o && rd_req_o));
endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_oe_o   (sda_oe_o),
  .wr_valid_o (wr_valid_o),
  .wr_commit_o(wr_commit_o),
  .wr_abort_o (wr_abort_o),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .start_ev   (start_ev),
  .stop_ev    (stop_ev),
  .fall_ev    (fall_ev),
  .phase      (phase)
);

// File: tb/eeprom_i2c_slave_bench.sv
module eeprom_i2c_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 25;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic        sda_line;
  logic [2:0]  strap = 3'b101;
  logic        busy = 1'b0;
  logic        wr_valid, wr_commit, wr_abort, rd_req;
  logic [12:0] wr_addr, rd_addr;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data = 8'h00;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int n_commit = 0;
  int n_abort = 0;
  bit done = 1'b0;

  int          wr_q_addr[$];
  int          wr_q_data[$];
  int          stage_addr[$];
  int          stage_data[$];
  logic [7:0]  env_mem[int];
  logic [7:0]  exp_mem[int];

  localparam logic [7:0] WH = {4'b1010, 3'b101, 1'b0};
  localparam logic [7:0] RH = {4'b1010, 3'b101, 1'b1};

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  eeprom_i2c_slave u_eeprom_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(strap), .busy_i(busy),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_commit_o(wr_commit), .wr_abort_o(wr_abort),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  // write engine and memory port environment
  always @(posedge clk) begin
    if (wr_valid) begin
      wr_q_addr.push_back(int'(wr_addr));
      wr_q_data.push_back(int'(wr_data));
      stage_addr.push_back(int'(wr_addr));
      stage_data.push_back(int'(wr_data));
    end
    if (wr_commit) begin
      n_commit++;
      foreach (stage_addr[i]) env_mem[stage_addr[i]] = stage_data[i][7:0];
      stage_addr.delete();
      stage_data.delete();
    end
    if (wr_abort) begin
      n_abort++;
      stage_addr.delete();
      stage_data.delete();
    end
    if (rd_req) rd_data <= env_mem.exists(int'(rd_addr)) ? env_mem[int'(rd_addr)] : 8'h00;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  // one bit; samples the line early and late in the SCL high phase
  task automatic bit_cycle(input logic b, input bit glitch, output logic s0, output logic s1);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q/2);
    if (glitch) begin
      sda_m = ~b; tick(2);
      sda_m = b;
    end
    tick(Q/2);
    s0 = sda_line; tick(Q);
    s1 = sda_line;
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, input bit glitch, output logic ack, output bit stable);
    logic s0, s1;
    stable = 1'b1;
    for (int i = 7; i >= 0; i--) bit_cycle(d[i], glitch && (i == 7), s0, s1);
    bit_cycle(1'b1, 1'b0, s0, s1);
    ack = ~s0;
    if (s0 != s1) stable = 1'b0;
  endtask

  task automatic rbyte(input bit master_ack, output logic [7:0] d, output bit stable);
    logic s0, s1;
    stable = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, 1'b0, s0, s1);
      d[i] = s0;
      if (s0 != s1) stable = 1'b0;
    end
    bit_cycle(~master_ack, 1'b0, s0, s1);
  endtask

  task automatic exp_ack(input logic [7:0] d, input logic exp, input string req, input string what);
    logic a; bit st;
    wbyte(d, 1'b0, a, st);
    chk(a == exp, req, what, int'(a), int'(exp));
  endtask

  task automatic set_addr(input logic [15:0] a);
    bus_start();
    exp_ack(WH, 1'b1, "R3", "write header ack");
    exp_ack(a[15:8], 1'b1, "R6", "addr hi ack");
    exp_ack(a[7:0], 1'b1, "R6", "addr lo ack");
  endtask

  task automatic read_seq(input string req, input int n, input int start_addr);
    logic [7:0] d; bit st; logic [7:0] e;
    exp_ack(RH, 1'b1, "R4", "read header ack");
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, d, st);
      e = exp_mem.exists((start_addr + i) % 8192) ? exp_mem[(start_addr + i) % 8192] : 8'h00;
      chk(d == e, req, "read byte", int'(d), int'(e));
      chk(st, "R5", "read data stable while SCL high", int'(st), 1);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic a; bit st; logic s0, s1; int c0;
    tick(5);
    chk(sda_oe == 1'b0 && wr_valid == 1'b0 && rd_req == 1'b0, "R1", "reset outputs", int'(sda_oe), 0);
    rst_n = 1'b1;
    tick(10);

    // R1: header bits without any start are ignored
    scl_m = 1'b0; tick(Q);
    exp_ack(WH, 1'b0, "R1", "no ack before start");
    bus_stop();

    // R2 R4 R7: write two bytes at 0x0123
    set_addr(16'h0123);
    exp_ack(8'h5A, 1'b1, "R5", "data ack");
    exp_ack(8'hC3, 1'b1, "R5", "data ack");
    c0 = n_commit;
    bus_stop();
    tick(5);
    exp_mem[16'h0123] = 8'h5A; exp_mem[16'h0124] = 8'hC3;
    chk(wr_q_addr.size() == 2, "R7", "write event count", wr_q_addr.size(), 2);
    if (wr_q_addr.size() == 2) begin
      chk(wr_q_addr[0] == 'h123 && wr_q_data[0] == 'h5A, "R7", "first write addr", wr_q_addr[0], 'h123);
      chk(wr_q_addr[1] == 'h124 && wr_q_data[1] == 'hC3, "R7", "second write addr", wr_q_addr[1], 'h124);
    end
    chk(n_commit == c0 + 1, "R2", "commit on stop", n_commit, c0 + 1);
    wr_q_addr.delete(); wr_q_data.delete();

    // R3: mismatched strap, mismatched type code
    bus_start();
    exp_ack({4'b1010, 3'b100, 1'b0}, 1'b0, "R3", "strap mismatch nack");
    bus_stop();
    bus_start();
    exp_ack({4'b1011, 3'b101, 1'b0}, 1'b0, "R3", "type mismatch nack");
    exp_ack(8'h00, 1'b0, "R3", "silent after mismatch");
    bus_stop();

    // R9: busy polling
    busy = 1'b1;
    bus_start();
    exp_ack(WH, 1'b0, "R9", "nack while busy");
    bus_stop();
    busy = 1'b0;
    c0 = n_commit;
    bus_start();
    exp_ack(WH, 1'b1, "R9", "ack when ready");
    bus_stop();
    tick(5);
    chk(n_commit == c0, "R2", "no commit without data", n_commit, c0);

    // R4 R11 R8: random read of one byte, then silence after nack
    set_addr(16'h0123);
    bus_start();
    read_seq("R11", 1, 'h123);
    bit_cycle(1'b1, 1'b0, s0, s1);
    chk(s0 == 1'b1 && s1 == 1'b1, "R8", "released after nack", int'(s0), 1);
    bus_stop();

    // R7: current address read continues at 0x0124
    bus_start();
    read_seq("R7", 2, 'h124);
    bus_stop();

    // R6: upper address bits ignored
    set_addr(16'hE124);
    bus_start();
    read_seq("R6", 1, 'h124);
    bus_stop();

    // R7: wrap from 8191 to 0 on write and read
    set_addr(16'h1FFF);
    exp_ack(8'h11, 1'b1, "R7", "data ack");
    exp_ack(8'h22, 1'b1, "R7", "data ack");
    bus_stop();
    tick(5);
    exp_mem[16'h1FFF] = 8'h11; exp_mem[0] = 8'h22;
    chk(wr_q_addr.size() == 2 && wr_q_addr[1] == 0, "R7", "write wrap addr",
        (wr_q_addr.size() == 2) ? wr_q_addr[1] : -1, 0);
    wr_q_addr.delete(); wr_q_data.delete();
    set_addr(16'h1FFF);
    bus_start();
    read_seq("R7", 2, 'h1FFF);
    bus_stop();

    // R2: repeated start before stop drops staged data
    c0 = n_abort;
    set_addr(16'h0200);
    exp_ack(8'h77, 1'b1, "R2", "data ack");
    bus_start();
    bus_stop();
    tick(5);
    chk(n_abort == c0 + 1, "R2", "abort on restart", n_abort, c0 + 1);
    set_addr(16'h0200);
    bus_start();
    read_seq("R2", 1, 'h200);
    bus_stop();
    wr_q_addr.delete(); wr_q_data.delete();

    // R10: short SCL pulse while low, short SDA pulse while SCL high
    set_addr(16'h0300);
    scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(Q);
    wbyte(8'h3C, 1'b1, a, st);
    chk(a == 1'b1, "R10", "ack after glitches", int'(a), 1);
    c0 = n_commit;
    bus_stop();
    tick(5);
    chk(n_commit == c0 + 1, "R10", "commit after glitches", n_commit, c0 + 1);
    chk(wr_q_addr.size() == 1 && wr_q_addr[0] == 'h300 && wr_q_data[0] == 'h3C, "R10", "glitched byte",
        (wr_q_data.size() == 1) ? wr_q_data[0] : -1, 'h3C);
    exp_mem[16'h0300] = 8'h3C;
    set_addr(16'h0300);
    bus_start();
    read_seq("R10", 1, 'h300);
    bus_stop();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule